// File: doc/BRIEF.md
# Ethertype-Keyed Header Walker

This block takes a packet as a byte stream, one byte per clock while a valid strobe is high, with a start marker on the first byte and an end marker on the last. A small state machine steps through the header chain. It begins with Ethernet. An optional VLAN header may follow, then an optional 6-byte routing tag, which can only appear after a VLAN header. The chain ends at IPv4. The ethertype at the end of each header selects the next step. Multi-byte fields are gathered big-endian: the first byte lands in the most significant position.

Walking stops in one of three ways:
- The chain reaches IPv4. This is the normal stop, and no IPv4 byte is extracted.
- An ethertype has no handled successor. This raises a type error.
- The end marker arrives before a header is complete. This raises a truncation error, and the partial header's valid bit stays low.

In every case a one-cycle done pulse follows. Presence bits, extracted fields and error flags then hold until the next start marker. Any bytes that arrive after the walk has finished, up to the end marker, are ignored.

Top module: `hdr_walk`

## Requirements
- R1: A byte is taken only in a cycle where `in_valid` is 1. Cycles with `in_valid` at 0 change no output, and `done` is 0 in the cycle after them.
- R2: A byte with `in_sop`=1 starts a new packet in any state, including mid-packet. It clears every presence bit and error flag. Bytes with `in_valid`=1 that arrive outside a packet, or after the walk finished, are ignored.
- R3: Ethernet occupies bytes 0..13: a 48-bit destination, a 48-bit source and a 16-bit type, each big-endian. `eth_ok` rises once byte 13 is taken.
- R4: An Ethernet type of 0x8100 or 0x9100 leads to VLAN. 0x0800 stops the walk with `ipv4_ok`=1.
- R5: The VLAN header is 4 bytes. Byte 0 bits 7:5 are the priority, bit 4 is CFI, and bits 3:0 with byte 1 form the 12-bit ID. Bytes 2..3 are the type. 0xAAAA leads to the routing tag and 0x0800 stops with `ipv4_ok`=1.
- R6: The routing tag is 6 bytes. Bytes 0..3 form `tag_route` (byte 0 in bits 31:24) and bytes 4..5 are its type, where 0x0800 stops with `ipv4_ok`=1. The tag type 0xAAAA directly after Ethernet is not handled.
- R7: Any other type at the end of a complete header sets `err_type`. The valid bit of that header stays set.
- R8: An end marker before the current header is complete sets `err_trunc` and leaves that header's valid bit 0. This includes an end marker on the last byte of a header whose type leads to VLAN or the tag.
- R9: `done` is high for exactly one cycle, the cycle after the byte that ends the walk. With it, exactly one of `ipv4_ok`, `err_type` or `err_trunc` is set. There is only one `done` per packet.
- R10: After reset, all flags, presence bits and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_byte | input | 8 | Packet byte |
| eth_ok | output | 1 | Ethernet header complete |
| vlan_ok | output | 1 | VLAN header complete |
| tag_ok | output | 1 | Routing tag complete |
| ipv4_ok | output | 1 | Walk reached IPv4 |
| dst_mac | output | 48 | Ethernet destination |
| src_mac | output | 48 | Ethernet source |
| eth_type | output | 16 | Ethernet type |
| vlan_pri | output | 3 | VLAN priority |
| vlan_cfi | output | 1 | VLAN CFI bit |
| vlan_id | output | 12 | VLAN ID |
| vlan_type | output | 16 | VLAN type |
| tag_route | output | 32 | Routing tag bytes 0..3 |
| tag_type | output | 16 | Routing tag type |
| done | output | 1 | One-cycle completion pulse |
| err_type | output | 1 | Unhandled type seen |
| err_trunc | output | 1 | Packet ended inside a header |

## Verification
The bench targets a set of boundary cases:
- **End marker exactly on a header's last byte.** Whether this gives truncation or a clean stop depends on the type. A design that checks the end marker before the type would misreport IPv4 packets as truncated, or miss truncation on VLAN-bound ones.
- **The tag type directly after Ethernet.** This must be an error. A design that routes to the tag from any state would accept it.
- **A new start marker mid-packet, and a one-byte packet.** A design that ignores a restart would keep stale flags or pulse done twice.
- **Idle gaps inside headers and trailing bytes after the stop.** A design that counts cycles instead of bytes would shift field bytes, and one that keeps walking after the stop would pulse done a second time.

// File: rtl/hdr_walk.sv
module hdr_walk #(
  parameter logic [15:0] TYPE_VLAN_A = 16'h8100,
  parameter logic [15:0] TYPE_VLAN_B = 16'h9100,
  parameter logic [15:0] TYPE_TAG    = 16'hAAAA,
  parameter logic [15:0] TYPE_IPV4   = 16'h0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_byte,
  output logic        eth_ok,
  output logic        vlan_ok,
  output logic        tag_ok,
  output logic        ipv4_ok,
  output logic [47:0] dst_mac,
  output logic [47:0] src_mac,
  output logic [15:0] eth_type,
  output logic [2:0]  vlan_pri,
  output logic        vlan_cfi,
  output logic [11:0] vlan_id,
  output logic [15:0] vlan_type,
  output logic [31:0] tag_route,
  output logic [15:0] tag_type,
  output logic        done,
  output logic        err_type,
  output logic        err_trunc
);
  localparam int ETH_LEN  = 14;
  localparam int VLAN_LEN = 4;
  localparam int TAG_LEN  = 6;
  localparam int CW       = $clog2(ETH_LEN);

  typedef enum logic [2:0] {S_IDLE, S_ETH, S_VLAN, S_TAG, S_SKIP} st_t;

  st_t          st, eff;
  logic [CW-1:0] cnt, ecnt;
  logic [15:0]  ntype;
  logic         hdr, last, go_vlan, go_tag, go_ip, fin;

  always_comb begin
    eff  = (in_valid && in_sop) ? S_ETH : st;
    ecnt = (in_valid && in_sop) ? '0 : cnt;
    case (eff)
      S_ETH:   ntype = {eth_type[7:0], in_byte};
      S_VLAN:  ntype = {vlan_type[7:0], in_byte};
      default: ntype = {tag_type[7:0], in_byte};
    endcase
  end

  assign hdr     = (eff == S_ETH) || (eff == S_VLAN) || (eff == S_TAG);
  assign last    = ((eff == S_ETH)  && (ecnt == CW'(ETH_LEN - 1))) ||
                   ((eff == S_VLAN) && (ecnt == CW'(VLAN_LEN - 1))) ||
                   ((eff == S_TAG)  && (ecnt == CW'(TAG_LEN - 1)));
  assign go_vlan = (eff == S_ETH) && ((ntype == TYPE_VLAN_A) || (ntype == TYPE_VLAN_B));
  assign go_tag  = (eff == S_VLAN) && (ntype == TYPE_TAG);
  assign go_ip   = ntype == TYPE_IPV4;
  assign fin     = last && !go_vlan && !go_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      eth_ok <= 1'b0; vlan_ok <= 1'b0; tag_ok <= 1'b0; ipv4_ok <= 1'b0;
      done <= 1'b0; err_type <= 1'b0; err_trunc <= 1'b0;
      dst_mac <= '0; src_mac <= '0; eth_type <= '0;
      vlan_pri <= '0; vlan_cfi <= 1'b0; vlan_id <= '0; vlan_type <= '0;
      tag_route <= '0; tag_type <= '0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        if (in_sop) begin
          eth_ok <= 1'b0; vlan_ok <= 1'b0; tag_ok <= 1'b0; ipv4_ok <= 1'b0;
          err_type <= 1'b0; err_trunc <= 1'b0;
        end
        case (eff)
          S_ETH: begin
            if (ecnt < CW'(6))       dst_mac  <= {dst_mac[39:0], in_byte};
            else if (ecnt < CW'(12)) src_mac  <= {src_mac[39:0], in_byte};
            else                     eth_type <= {eth_type[7:0], in_byte};
          end
          S_VLAN: begin
            if (ecnt == CW'(0)) begin
              vlan_pri      <= in_byte[7:5];
              vlan_cfi      <= in_byte[4];
              vlan_id[11:8] <= in_byte[3:0];
            end else if (ecnt == CW'(1)) vlan_id[7:0] <= in_byte;
            else vlan_type <= {vlan_type[7:0], in_byte};
          end
          S_TAG: begin
            if (ecnt < CW'(4)) tag_route <= {tag_route[23:0], in_byte};
            else               tag_type  <= {tag_type[7:0], in_byte};
          end
          default: ;
        endcase
        if (hdr) begin
          if (!last) begin
            st  <= eff;
            cnt <= ecnt + CW'(1);
          end else begin
            case (eff)
              S_ETH:   eth_ok  <= 1'b1;
              S_VLAN:  vlan_ok <= 1'b1;
              default: tag_ok  <= 1'b1;
            endcase
            cnt <= '0;
            if (go_vlan)     st <= S_VLAN;
            else if (go_tag) st <= S_TAG;
            else begin
              st   <= S_SKIP;
              done <= 1'b1;
              if (go_ip) ipv4_ok  <= 1'b1;
              else       err_type <= 1'b1;
            end
          end
        end
        if (in_eop) begin
          st <= S_IDLE;
          if (hdr && !fin) begin
            err_trunc <= 1'b1;
            done      <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module hdr_walk_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sop,
  input logic in_eop,
  input logic eth_ok,
  input logic vlan_ok,
  input logic tag_ok,
  input logic ipv4_ok,
  input logic done,
  input logic err_type,
  input logic err_trunc
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable({eth_ok, vlan_ok, tag_ok, ipv4_ok, err_type, err_trunc}) && !done));
  assert_sop_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !in_eop) |=> (!ipv4_ok && !err_type && !err_trunc && !eth_ok));
  assert_ipv4_needs_eth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ipv4_ok |-> eth_ok);
  assert_vlan_needs_eth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vlan_ok |-> eth_ok);
  assert_tag_needs_vlan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_ok |-> (vlan_ok && eth_ok));
  assert_trunc_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_trunc |-> !tag_ok);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ipv4_ok, err_type, err_trunc}) == 1));
  assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ipv4_ok, err_type, err_trunc}) <= 1);
endmodule

bind hdr_walk hdr_walk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
  .eth_ok(eth_ok), .vlan_ok(vlan_ok), .tag_ok(tag_ok), .ipv4_ok(ipv4_ok),
  .done(done), .err_type(err_type), .err_trunc(err_trunc)
);

// File: tb/hdr_walk_test.sv
`timescale 1ns/1ps
module hdr_walk_test;
  logic clk = 0, rst_n = 0, in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_byte = 0;
  logic eth_ok, vlan_ok, tag_ok, ipv4_ok, done, err_type, err_trunc, vlan_cfi;
  logic [47:0] dst_mac, src_mac;
  logic [15:0] eth_type, vlan_type, tag_type;
  logic [2:0] vlan_pri;
  logic [11:0] vlan_id;
  logic [31:0] tag_route;

  always #2.5 clk = ~clk;

  hdr_walk uut (.*);

  int checks = 0, errors = 0;
  bit ended = 0;

  logic [7:0] mq[$];
  logic [7:0] pk[$];
  bit active = 0, m_done = 0, fin = 0;
  bit m_eth = 0, m_vlan = 0, m_tag = 0, m_ip = 0, m_et = 0, m_tr = 0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic void mparse(input bit at_eop);
    int n = mq.size();
    logic [15:0] t;
    m_eth = 0; m_vlan = 0; m_tag = 0; m_ip = 0; m_et = 0; m_tr = 0; fin = 0;
    if (n < 14) begin if (at_eop) begin m_tr = 1; fin = 1; end return; end
    m_eth = 1; t = {mq[12], mq[13]};
    if (t == 16'h0800) begin m_ip = 1; fin = 1; return; end
    if (t != 16'h8100 && t != 16'h9100) begin m_et = 1; fin = 1; return; end
    if (n < 18) begin if (at_eop) begin m_tr = 1; fin = 1; end return; end
    m_vlan = 1; t = {mq[16], mq[17]};
    if (t == 16'h0800) begin m_ip = 1; fin = 1; return; end
    if (t != 16'hAAAA) begin m_et = 1; fin = 1; return; end
    if (n < 24) begin if (at_eop) begin m_tr = 1; fin = 1; end return; end
    m_tag = 1; t = {mq[22], mq[23]};
    if (t == 16'h0800) m_ip = 1; else m_et = 1;
    fin = 1;
  endfunction

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      active = 0; mq.delete();
      m_eth = 0; m_vlan = 0; m_tag = 0; m_ip = 0; m_et = 0; m_tr = 0;
    end else if (in_valid) begin
      if (in_sop) begin active = 1; mq.delete(); end
      if (active) begin
        mq.push_back(in_byte);
        mparse(in_eop);
        if (fin) begin m_done = 1; active = 0; end
      end
      if (in_eop) active = 0;
    end
  end

  always @(negedge clk) if (rst_n && !ended) begin
    chk("R3 eth_ok", eth_ok, m_eth);
    chk("R5 vlan_ok", vlan_ok, m_vlan);
    chk("R6 tag_ok", tag_ok, m_tag);
    chk("R4 ipv4_ok", ipv4_ok, m_ip);
    chk("R7 err_type", err_type, m_et);
    chk("R8 err_trunc", err_trunc, m_tr);
    chk("R9 done", done, m_done);
    if (m_eth) begin
      chk("R3 dst_mac", dst_mac, {mq[0], mq[1], mq[2], mq[3], mq[4], mq[5]});
      chk("R3 src_mac", src_mac, {mq[6], mq[7], mq[8], mq[9], mq[10], mq[11]});
      chk("R3 eth_type", eth_type, {mq[12], mq[13]});
    end
    if (m_vlan) begin
      chk("R5 vlan_pri", vlan_pri, mq[14][7:5]);
      chk("R5 vlan_cfi", vlan_cfi, mq[14][4]);
      chk("R5 vlan_id", vlan_id, {mq[14][3:0], mq[15]});
      chk("R5 vlan_type", vlan_type, {mq[16], mq[17]});
    end
    if (m_tag) begin
      chk("R6 tag_route", tag_route, {mq[18], mq[19], mq[20], mq[21]});
      chk("R6 tag_type", tag_type, {mq[22], mq[23]});
    end
  end

  task automatic rnd(input int n);
    for (int i = 0; i < n; i++) pk.push_back(8'($urandom));
  endtask
  task automatic add_eth(input logic [15:0] t); rnd(12); pk.push_back(t[15:8]); pk.push_back(t[7:0]); endtask
  task automatic add_vlan(input logic [15:0] t); rnd(2); pk.push_back(t[15:8]); pk.push_back(t[7:0]); endtask
  task automatic add_tag(input logic [15:0] t); rnd(4); pk.push_back(t[15:8]); pk.push_back(t[7:0]); endtask

  task automatic send(input int gap);
    for (int i = 0; i < pk.size(); i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == pk.size() - 1); in_byte = pk[i];
      if (gap != 0 && (i % gap) == gap - 1) begin
        @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; in_byte = 8'hEE;
      end
    end
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
    pk.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic outcome(input string r, input logic ip, input logic et, input logic tr);
    chk(r, {ipv4_ok, err_type, err_trunc}, {ip, et, tr});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 flags", {eth_ok, vlan_ok, tag_ok, ipv4_ok, done, err_type, err_trunc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 flags after release", {eth_ok, ipv4_ok, done, err_type, err_trunc}, 0);

    add_eth(16'h0800); rnd(5); send(3);
    outcome("R1 R4 ipv4 with gaps", 1, 0, 0);
    add_eth(16'h8100); add_vlan(16'h0800); send(0);
    outcome("R5 vlan to ipv4", 1, 0, 0); chk("R5 vlan_ok", vlan_ok, 1);
    add_eth(16'h9100); add_vlan(16'hAAAA); add_tag(16'h0800); rnd(6); send(5);
    outcome("R6 tag to ipv4", 1, 0, 0); chk("R6 tag_ok", tag_ok, 1);
    add_eth(16'hAAAA); rnd(4); send(0);
    outcome("R6 tag after eth rejected", 0, 1, 0); chk("R7 eth_ok kept", eth_ok, 1);
    add_eth(16'h8100); add_vlan(16'h1234); send(0);
    outcome("R7 vlan unhandled", 0, 1, 0);
    add_eth(16'h8100); add_vlan(16'hAAAA); add_tag(16'h86DD); send(0);
    outcome("R7 tag unhandled", 0, 1, 0);
    rnd(9); send(0);
    outcome("R8 trunc in eth", 0, 0, 1); chk("R8 eth_ok low", eth_ok, 0);
    add_eth(16'h8100); add_vlan(16'hAAAA); rnd(3); send(2);
    outcome("R8 trunc in tag", 0, 0, 1); chk("R8 tag_ok low", tag_ok, 0);
    add_eth(16'h8100); send(0);
    outcome("R8 eop at eth end to vlan", 0, 0, 1);
    add_eth(16'h8100); add_vlan(16'h0800); send(0);
    outcome("R9 eop at vlan end to ipv4", 1, 0, 0);
    rnd(7); pk.push_back(8'h00); send(0);
    // R2: restart mid-packet with a new start marker
    rnd(5); send_restart();
    outcome("R2 restart", 1, 0, 0);
    pk.push_back(8'h55); send(0);
    outcome("R8 single byte", 0, 0, 1);
    // R2: stray bytes outside a packet are ignored
    @(negedge clk); in_valid = 1; in_byte = 8'h81; @(negedge clk); in_valid = 0;
    @(negedge clk);
    outcome("R2 stray byte ignored", 0, 0, 1);

    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_restart();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_sop = (i == 0); in_eop = 0; in_byte = pk[i];
    end
    pk.delete();
    add_eth(16'h0800);
    send(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule